// File: doc/BRIEF.md
# Bus-Activity Watchdog Reset Supervisor

This block drives a system reset from three causes: power-up, loss of a supply-good flag from an external comparator, and expiry of a watchdog. The watchdog needs no dedicated kick pin. Software restarts it by placing a START condition and then a STOP condition on an existing two-wire bus. The block watches the synchronized SCL and SDA samples for that pair. Time is measured in pulses of a 1 ms tick input, so every period below is a count of tick pulses.

The watchdog period comes from a two-bit select register. Four codes give three periods and an off setting. A simple write strobe loads the register, and a write-protect input blocks that write. The register is not cleared by the block's logic reset, which models retained storage. Reset is released only after the supply flag has stayed good for an unbroken delay. After a watchdog expiry, reset is held for that same delay. The reset state is offered in two polarities.

Top module: `bus_wdog_supervisor`

## Requirements
- R1: After `rst_n` is released, the reset outputs stay asserted. They are released on the clock edge that samples the 200th `tick_ms` pulse counted while `supply_ok` has been high without a break.
- R2: When `supply_ok` is low, reset is asserted in the same clock cycle. The release count restarts from zero, so a one-cycle drop needs a full new 200 ticks after `supply_ok` returns high.
- R3: `rst_out` is active high and `rst_out_n` is active low. The two are always complementary.
- R4: Select codes give these periods: `00` = 1400 ticks, `01` = 600 ticks, `10` = 200 ticks. If no restart happens, reset asserts on the edge that samples the Nth tick after the watchdog counter was last cleared.
- R5: Select code `11` turns the watchdog off, and no timeout ever occurs.
- R6: A START (SDA falls while SCL is high) followed later by a STOP (SDA rises while SCL is high) clears the watchdog counter. The clear happens on the edge where the STOP is seen.
- R7: A START with no STOP after it does not restart the watchdog. A STOP with no START before it does not restart the watchdog either.
- R8: While `wp` is high, a write to the select register is ignored. The previous period stays in force.
- R9: The select value survives assertion of `rst_n`. Only an accepted write changes it.
- R10: After a watchdog timeout, reset is held for 200 ticks and then released. The watchdog counter stays at zero while reset is active and starts from zero after release.
- R11: An accepted select write clears the watchdog counter. The new period is then timed in full from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| scl | input | 1 | Synchronized bus clock sample |
| sda | input | 1 | Synchronized bus data sample |
| supply_ok | input | 1 | Supply-good flag from the comparator |
| wp | input | 1 | Write protect for the select register |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | 2 | Select value to write |
| rst_out | output | 1 | Active-high system reset |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
Each enabled select code is timed to the exact tick, one tick before and on expiry. This separates the three periods and catches off-by-one errors in the counter and the hold delay. Bus tests compare a proper START/STOP restart with a lone START and with a lone STOP, so the arm-then-complete order is checked. Further tests cover a protected write, a period change while running, a logic reset with the select already set, a one-cycle supply glitch and the off code. Each one shows whether the period in force and the counter clear follow the rules.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
  // Watchdog period select; the encoding is decoded by the timer
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic kick_o
);
  logic scl_q, sda_q, armed_q;
  logic armed_d, start_c, stop_c;

  always_comb begin
    start_c = scl & scl_q & sda_q & ~sda;
    stop_c  = scl & scl_q & ~sda_q & sda;
    armed_d = armed_q;
    if (start_c)     armed_d = 1'b1;
    else if (stop_c) armed_d = 1'b0;
    kick_o  = stop_c & armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      scl_q   <= scl;
      sda_q   <= sda;
      armed_q <= armed_d;
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && scl_q && sda_q && !sda) |=> armed_q); // R6
  AST_KICK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |=> !armed_q); // R7
endmodule

// File: rtl/reset_hold.sv
module reset_hold #(
  parameter int unsigned DLY_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_expire,
  output logic in_reset_o
);
  localparam int unsigned CW = $clog2(DLY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY_TICKS - 1);

  logic          in_reset_q, in_reset_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    in_reset_d = in_reset_q;
    cnt_d      = cnt_q;
    if (!supply_ok || wd_expire) begin
      in_reset_d = 1'b1;
      cnt_d      = '0;
    end else if (in_reset_q && tick) begin
      if (cnt_q == LAST) begin
        in_reset_d = 1'b0;
        cnt_d      = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reset_q <= 1'b1;
      cnt_q      <= '0;
    end else begin
      in_reset_q <= in_reset_d;
      cnt_q      <= cnt_d;
    end
  end

  assign in_reset_o = in_reset_q;

  AST_SUPPLY_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> in_reset_q && cnt_q == '0); // R2
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_reset_q) |-> $past(supply_ok) && $past(tick)); // R1
  AST_EXPIRE_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> in_reset_q); // R10
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdsup_pkg::*;
#(
  parameter int unsigned T_LONG  = 1400,
  parameter int unsigned T_MID   = 600,
  parameter int unsigned T_SHORT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold,
  input  logic       kick,
  input  logic       wp,
  input  logic       sel_we,
  input  logic [1:0] sel_wdata,
  output logic       expire_o
);
  localparam int unsigned TMAX = (T_LONG > T_MID) ?
                                 ((T_LONG > T_SHORT) ? T_LONG : T_SHORT) :
                                 ((T_MID > T_SHORT) ? T_MID : T_SHORT);
  localparam int unsigned CW = $clog2(TMAX + 1);

  wd_sel_e       sel_q;
  logic          sel_wr, run;
  logic [CW-1:0] lim_last;
  logic [CW-1:0] wcnt_q, wcnt_d;

  // Retained select: deliberately outside the logic reset
  always_ff @(posedge clk) begin
    if (sel_wr) sel_q <= wd_sel_e'(sel_wdata);
  end

  always_comb begin
    sel_wr = sel_we & ~wp;
    unique case (sel_q)
      WD_LONG:  lim_last = CW'(T_LONG - 1);
      WD_MID:   lim_last = CW'(T_MID - 1);
      WD_SHORT: lim_last = CW'(T_SHORT - 1);
      default:  lim_last = '0;
    endcase
    run      = (sel_q != WD_OFF) & ~hold;
    expire_o = run & tick & (wcnt_q == lim_last) & ~kick & ~sel_wr;
    wcnt_d   = wcnt_q;
    if (!run || kick || sel_wr || expire_o) wcnt_d = '0;
    else if (tick)                          wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end

  AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && wp) |=> $stable(sel_q)); // R8
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && !wp) |=> wcnt_q == '0); // R11
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> wcnt_q == '0); // R6
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> wcnt_q == '0); // R10
  AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == WD_OFF) |-> !expire_o); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= CW'(TMAX)); // R4
endmodule

// File: rtl/bus_wdog_supervisor.sv
module bus_wdog_supervisor #(
  parameter int unsigned DLY_TICKS = 200,
  parameter int unsigned T_LONG    = 1400,
  parameter int unsigned T_MID     = 600,
  parameter int unsigned T_SHORT   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       scl,
  input  logic       sda,
  input  logic       supply_ok,
  input  logic       wp,
  input  logic       sel_we,
  input  logic [1:0] sel_wdata,
  output logic       rst_out,
  output logic       rst_out_n
);
  logic kick, expire, in_reset, rst_active;

  bus_cond_detect u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl    (scl),
    .sda    (sda),
    .kick_o (kick)
  );

  reset_hold #(.DLY_TICKS(DLY_TICKS)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_ms),
    .supply_ok  (supply_ok),
    .wd_expire  (expire),
    .in_reset_o (in_reset)
  );

  wdog_timer #(.T_LONG(T_LONG), .T_MID(T_MID), .T_SHORT(T_SHORT)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_ms),
    .hold      (rst_active),
    .kick      (kick),
    .wp        (wp),
    .sel_we    (sel_we),
    .sel_wdata (sel_wdata),
    .expire_o  (expire)
  );

  // Supply loss reaches the pins without waiting for a clock edge
  assign rst_active = in_reset | ~supply_ok;
  assign rst_out    = rst_active;
  assign rst_out_n  = ~rst_active;

  AST_POLARITY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out != rst_out_n); // R3
  AST_SUPPLY_TO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> rst_out && !rst_out_n); // R2
endmodule

// File: tb/tb_bus_wdog_supervisor.sv
module tb_bus_wdog_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 200;
  // {select code, period in ticks}
  localparam logic [15:0] VEC [3] = '{
    {2'b00, 14'd1400},
    {2'b01, 14'd600},
    {2'b10, 14'd200}
  };

  logic clk, rst_n, tick_ms, scl, sda, supply_ok, wp, sel_we;
  logic [1:0] sel_wdata;
  logic rst_out, rst_out_n;
  int checks, fails;
  bit done;

  bus_wdog_supervisor dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .scl(scl), .sda(sda),
    .supply_ok(supply_ok), .wp(wp), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .rst_out(rst_out), .rst_out_n(rst_out_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (rst_out !== exp || rst_out_n !== ~exp) begin
      fails++;
      $display("FAIL %s: rst_out=%b rst_out_n=%b expected rst_out=%b rst_out_n=%b",
               tag, rst_out, rst_out_n, exp, ~exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic bus(input logic c, input logic d);
    @(negedge clk) begin scl = c; sda = d; end
  endtask

  task automatic bus_start();
    bus(1, 1); bus(1, 0); bus(0, 0);
  endtask

  task automatic bus_stop();
    bus(0, 0); bus(1, 0); bus(1, 1);
  endtask

  task automatic bus_stop_only();
    bus(0, 1); bus(0, 0); bus(1, 0); bus(1, 1);
  endtask

  task automatic wr_sel(input logic [1:0] v);
    @(negedge clk) begin sel_we = 1'b1; sel_wdata = v; end
    @(negedge clk) sel_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 0; tick_ms = 0; scl = 1; sda = 1; supply_ok = 0;
    wp = 0; sel_we = 0; sel_wdata = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(1'b1, "R1 R3 reset state");
    supply_ok = 1'b1;
    ticks(DLY - 1); chk(1'b1, "R1 held before delay");
    ticks(1);       chk(1'b0, "R1 R3 released after delay");

    // Period table
    for (int v = 0; v < 3; v++) begin
      wr_sel(VEC[v][15:14]);
      ticks(int'(VEC[v][13:0]) - 1); chk(1'b0, "R4 no timeout before period");
      ticks(1);                      chk(1'b1, "R4 timeout at period");
      ticks(DLY - 1);                chk(1'b1, "R10 held after timeout");
      ticks(1);                      chk(1'b0, "R10 released after hold");
    end

    // R6 proper restart, select is 10 (200 ticks)
    ticks(150); bus_start(); bus_stop();
    ticks(199); chk(1'b0, "R6 restart cleared counter");
    ticks(1);   chk(1'b1, "R6 timeout counted from restart");
    ticks(DLY); chk(1'b0, "R10 recovered");

    // R7 START alone
    ticks(150); bus_start();
    ticks(49);  chk(1'b0, "R7 start-only before period");
    ticks(1);   chk(1'b1, "R7 start-only does not restart");
    bus_stop();
    ticks(DLY); chk(1'b0, "R10 recovered");

    // R7 STOP alone
    ticks(150); bus_stop_only();
    ticks(49);  chk(1'b0, "R7 stop-only before period");
    ticks(1);   chk(1'b1, "R7 stop-only does not restart");
    ticks(DLY); chk(1'b0, "R10 recovered");

    // R8 protected write of the off code is ignored
    wp = 1'b1; wr_sel(2'b11); wp = 1'b0;
    ticks(199); chk(1'b0, "R8 before period");
    ticks(1);   chk(1'b1, "R8 protected write ignored");
    ticks(DLY); chk(1'b0, "R10 recovered");

    // R11 select change restarts timing
    wr_sel(2'b01); ticks(500); wr_sel(2'b10);
    ticks(199); chk(1'b0, "R11 write cleared counter");
    ticks(1);   chk(1'b1, "R11 new period from write");
    ticks(DLY); chk(1'b0, "R10 recovered");

    // R9 select retained over logic reset
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) chk(1'b1, "R9 reset during rst_n");
    rst_n = 1'b1;
    ticks(DLY - 1); chk(1'b1, "R1 held after rst_n");
    ticks(1);       chk(1'b0, "R1 released after rst_n");
    ticks(199);     chk(1'b0, "R9 before retained period");
    ticks(1);       chk(1'b1, "R9 retained 200 period");
    ticks(DLY);     chk(1'b0, "R10 recovered");

    // R2 supply loss and glitch
    @(negedge clk) supply_ok = 1'b0;
    #1 chk(1'b1, "R2 same-cycle assert");
    @(negedge clk) supply_ok = 1'b1;
    ticks(100);
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk) supply_ok = 1'b1;
    ticks(DLY - 1); chk(1'b1, "R2 delay restarted after glitch");
    ticks(1);       chk(1'b0, "R2 released after full delay");

    // R5 off code
    wr_sel(2'b11);
    ticks(1500); chk(1'b0, "R5 off never times out");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule